// File: doc/BRIEF.md
# Deferred Program-Bank and Feature-Enable Decoder

This unit sits next to the instruction decoder of a small 8-bit controller core. It watches every fetched opcode byte. Two opcodes arm a pending program-bank bit. A third opcode sets a sticky enable for address-line-20 gating hardware. The unit also owns the 12-bit program counter. Sequential fetches advance only the lower 11 bits of that counter. Bit 11 is loaded from the pending bank bit only when a jump or call is taken.

A bank-select opcode therefore never moves the fetch address when it executes. Code running in one 2 KiB half of program memory keeps running there until the next taken jump or call. That transfer lands in the half that was armed. Two small state machines hold the pending bank (`BANK_LO`, `BANK_HI`) and the feature flag (`FEAT_OFF`, `FEAT_ON`). A register process holds the counter.

Transitions:
- `BANK_LO`→`BANK_HI` on select-upper.
- `BANK_HI`→`BANK_LO` on select-lower.
- `FEAT_OFF`→`FEAT_ON` on feature-enable.
- Only reset returns the feature machine to `FEAT_OFF`.

Top module: `pgbank_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_out` is 000h and `a20_en` is 0. The pending bank bit resets to lower (0).
- R2: An accepted opcode 63h arms the lower bank. The next taken jump or call then drives `pc_out[11]` to 0, so the fetch address lies in 000h–7FFh.
- R3: An accepted opcode 73h arms the upper bank. The next taken jump or call then drives `pc_out[11]` to 1, so the fetch address lies in 800h–FFFh.
- R4: A bank-select opcode does not change `pc_out[11]` in the cycle after it is accepted unless a jump is taken in that same cycle.
- R5: When `jump_take` is high at a clock edge, `pc_out` becomes {pending bank, `jump_target`} on that edge.
- R6: When `pc_step` is high and `jump_take` is low, `pc_out[10:0]` increments modulo 2048 and `pc_out[11]` is kept (7FFh→000h, FFFh→800h).
- R7: An accepted opcode 33h sets `a20_en` from the next cycle onward. It stays set through any later opcodes and jumps, and only reset clears it.
- R8: If a select opcode and a taken jump coincide, the jump uses the bank bit that was pending before that edge. The new selection applies to the following jump.
- R9: Any other opcode, and any byte presented with `op_valid` low, leaves the pending bank and `a20_en` unchanged.
- R10: `jump_take` has priority over `pc_step`. With neither asserted, `pc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte is valid this cycle |
| op_byte | input | 8 | Fetched opcode |
| jump_take | input | 1 | A jump or call is taken this cycle |
| jump_target | input | 11 | Lower 11 bits of the jump/call destination |
| pc_step | input | 1 | Sequential increment request |
| pc_out | output | 12 | Program counter |
| a20_en | output | 1 | Sticky A20-gate feature enable |

## Verification
The bench targets these corner cases:

- **Select opcode and jump in the same edge.** A design that forwards the fresh selection would land the jump in the wrong half.
- **Increment from 7FFh and from FFFh.** A carry that leaks into bit 11 would silently cross banks.
- **Select opcode with no jump following.** A design that applies bank bits immediately would move `pc_out[11]`.
- **Distractor bytes and invalid-strobe bytes.** These check that lookalike opcodes and unaccepted bytes neither arm a bank nor set the feature.
- **Reset after the feature flag is set.** This checks that the flag clears only through reset.

Randomised traffic then compares every cycle against a bench model of the counter, the pending bank and the flag.

// File: rtl/pgbank_pkg.sv
`timescale 1ns/1ps
package pgbank_pkg;
    localparam int unsigned LO_W = 11;
    localparam int unsigned OP_W = 8;

    localparam logic [OP_W-1:0] OPC_SEL_LO  = 8'h63;
    localparam logic [OP_W-1:0] OPC_SEL_HI  = 8'h73;
    localparam logic [OP_W-1:0] OPC_FEAT_ON = 8'h33;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_state_e;

    typedef enum logic {
        FEAT_OFF = 1'b0,
        FEAT_ON  = 1'b1
    } feat_state_e;

    typedef struct packed {
        logic sel_lo;
        logic sel_hi;
        logic feat_on;
    } op_cmd_t;
endpackage

// File: rtl/pgbank_opdec.sv
`timescale 1ns/1ps
module pgbank_opdec
    import pgbank_pkg::*;
#(
    parameter int unsigned W = OP_W
) (
    input  logic         op_valid,
    input  logic [W-1:0] op_byte,
    output op_cmd_t      cmd
);
    always_comb begin
        cmd = '0;
        if (op_valid) begin
            unique case (op_byte)
                OPC_SEL_LO:  cmd.sel_lo  = 1'b1;
                OPC_SEL_HI:  cmd.sel_hi  = 1'b1;
                OPC_FEAT_ON: cmd.feat_on = 1'b1;
                default:     cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/pgbank_bank_fsm.sv
`timescale 1ns/1ps
module pgbank_bank_fsm
    import pgbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  op_cmd_t cmd,
    output logic    bank_hi
);
    bank_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BANK_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_LO: if (cmd.sel_hi) state_d = BANK_HI;
            BANK_HI: if (cmd.sel_lo) state_d = BANK_LO;
            default: state_d = BANK_LO;
        endcase
    end

    always_comb begin
        bank_hi = (state_q == BANK_HI);
    end
endmodule

// File: rtl/pgbank_feat_fsm.sv
`timescale 1ns/1ps
module pgbank_feat_fsm
    import pgbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  op_cmd_t cmd,
    output logic    feat_en
);
    feat_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FEAT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEAT_OFF: if (cmd.feat_on) state_d = FEAT_ON;
            FEAT_ON:  state_d = FEAT_ON;
            default:  state_d = FEAT_OFF;
        endcase
    end

    always_comb begin
        feat_en = (state_q == FEAT_ON);
    end
endmodule

// File: rtl/pgbank_pc_reg.sv
`timescale 1ns/1ps
module pgbank_pc_reg #(
    parameter int unsigned LW = 11,
    localparam int unsigned PW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          jump_take,
    input  logic [LW-1:0] jump_target,
    input  logic          pc_step,
    input  logic          bank_hi,
    output logic [PW-1:0] pc
);
    logic [PW-1:0] pc_q, pc_d;
    logic [LW-1:0] lo_inc;

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    always_comb begin
        lo_inc = pc_q[LW-1:0] + {{(LW-1){1'b0}}, 1'b1};
        pc_d   = pc_q;
        if (jump_take)    pc_d = {bank_hi, jump_target};
        else if (pc_step) pc_d = {pc_q[LW], lo_inc};
    end

    always_comb begin
        pc = pc_q;
    end
endmodule

// File: rtl/pgbank_ctl.sv
`timescale 1ns/1ps
module pgbank_ctl
    import pgbank_pkg::*;
#(
    parameter int unsigned LW = LO_W,
    localparam int unsigned PW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [7:0]    op_byte,
    input  logic          jump_take,
    input  logic [LW-1:0] jump_target,
    input  logic          pc_step,
    output logic [PW-1:0] pc_out,
    output logic          a20_en
);
    op_cmd_t cmd;
    logic    bank_hi;

    pgbank_opdec #(.W(8)) u_dec (
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .cmd      (cmd)
    );

    pgbank_bank_fsm u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .bank_hi (bank_hi)
    );

    pgbank_feat_fsm u_feat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .feat_en (a20_en)
    );

    pgbank_pc_reg #(.LW(LW)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .jump_take   (jump_take),
        .jump_target (jump_target),
        .pc_step     (pc_step),
        .bank_hi     (bank_hi),
        .pc          (pc_out)
    );
endmodule

// File: rtl/pgbank_ctl_chk.sv
`timescale 1ns/1ps
module pgbank_ctl_chk #(
    parameter int unsigned LW = 11,
    localparam int unsigned PW = LW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [7:0]    op_byte,
    input logic          jump_take,
    input logic [LW-1:0] jump_target,
    input logic          pc_step,
    input logic [PW-1:0] pc_out,
    input logic          a20_en,
    input logic          bank_hi
);
    a_r2_sel_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte == 8'h63) |=> !bank_hi);

    a_r3_sel_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte == 8'h73) |=> bank_hi);

    a_r4_no_early_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !jump_take |=> pc_out[LW] == $past(pc_out[LW]));

    a_r5_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        jump_take |=> pc_out[LW-1:0] == $past(jump_target));

    a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_take && pc_step) |=>
            (pc_out[LW-1:0] == $past(pc_out[LW-1:0]) + 1'b1) && (pc_out[LW] == $past(pc_out[LW])));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        a20_en |=> a20_en);

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte == 8'h33) |=> a20_en);

    a_r8_old_bank: assert property (@(posedge clk) disable iff (!rst_n)
        jump_take |=> pc_out[LW] == $past(bank_hi));

    a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || (op_byte != 8'h63 && op_byte != 8'h73)) |=> $stable(bank_hi));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_take && !pc_step) |=> $stable(pc_out));
endmodule

bind pgbank_ctl pgbank_ctl_chk #(.LW(LW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_byte     (op_byte),
    .jump_take   (jump_take),
    .jump_target (jump_target),
    .pc_step     (pc_step),
    .pc_out      (pc_out),
    .a20_en      (a20_en),
    .bank_hi     (bank_hi)
);

// File: tb/pgbank_ctl_tb_top.sv
`timescale 1ns/1ps
module pgbank_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic        jump_take = 1'b0;
    logic [10:0] jump_target = '0;
    logic        pc_step = 1'b0;
    logic [11:0] pc_out;
    logic        a20_en;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [11:0] m_pc = '0;
    logic        m_pend = 1'b0;
    logic        m_a20 = 1'b0;

    always #4 clk = ~clk;

    pgbank_ctl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_byte     (op_byte),
        .jump_take   (jump_take),
        .jump_target (jump_target),
        .pc_step     (pc_step),
        .pc_out      (pc_out),
        .a20_en      (a20_en)
    );

    function automatic logic [11:0] next_pc(logic [11:0] pc, logic pend,
                                            logic j, logic [10:0] t, logic s);
        if (j)      return {pend, t};
        else if (s) return {pc[11], pc[10:0] + 11'd1};
        return pc;
    endfunction

    function automatic logic next_pend(logic pend, logic v, logic [7:0] op);
        if (v && op == 8'h63) return 1'b0;
        if (v && op == 8'h73) return 1'b1;
        return pend;
    endfunction

    task automatic chk(string tag, logic [11:0] act_pc, logic act_a);
        n_run++;
        if (act_pc !== m_pc || act_a !== m_a20) begin
            n_fail++;
            $display("FAIL %s: pc=%03h a20=%0b expected pc=%03h a20=%0b",
                     tag, act_pc, act_a, m_pc, m_a20);
        end
    endtask

    task automatic cyc(string tag, logic v, logic [7:0] op, logic j,
                       logic [10:0] t, logic s);
        op_valid = v; op_byte = op; jump_take = j; jump_target = t; pc_step = s;
        m_pc   = next_pc(m_pc, m_pend, j, t, s);
        m_pend = next_pend(m_pend, v, op);
        if (v && op == 8'h33) m_a20 = 1'b1;
        @(negedge clk);
        chk(tag, pc_out, a20_en);
        op_valid = 1'b0; jump_take = 1'b0; pc_step = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_pc = '0; m_pend = 1'b0; m_a20 = 1'b0;
        chk("R1 in reset", pc_out, a20_en);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", pc_out, a20_en);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run state=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R6 plain increments
        cyc("R6", 1'b0, 8'h00, 1'b0, 11'h0, 1'b1);
        cyc("R6", 1'b0, 8'h00, 1'b0, 11'h0, 1'b1);
        cyc("R6", 1'b0, 8'h00, 1'b0, 11'h0, 1'b1);

        // R4: select upper, no jump, bit 11 stays low
        cyc("R4", 1'b1, 8'h73, 1'b0, 11'h0, 1'b1);
        cyc("R4", 1'b0, 8'h00, 1'b0, 11'h0, 1'b0);

        // R3 / R5: jump lands in upper half
        cyc("R3", 1'b0, 8'h00, 1'b1, 11'h123, 1'b0);

        // R8: select lower coincides with jump, old bank applies
        cyc("R8", 1'b1, 8'h63, 1'b1, 11'h7FF, 1'b0);

        // R2: next jump takes lower bank
        cyc("R2", 1'b0, 8'h00, 1'b1, 11'h010, 1'b0);

        // R6 wrap inside lower half: 7FF -> 000
        cyc("R6", 1'b0, 8'h00, 1'b1, 11'h7FF, 1'b0);
        cyc("R6 wrap lo", 1'b0, 8'h00, 1'b0, 11'h0, 1'b1);

        // R6 wrap inside upper half: FFF -> 800
        cyc("R3", 1'b1, 8'h73, 1'b0, 11'h0, 1'b0);
        cyc("R5", 1'b0, 8'h00, 1'b1, 11'h7FF, 1'b0);
        cyc("R6 wrap hi", 1'b0, 8'h00, 1'b0, 11'h0, 1'b1);

        // R9: distractors and invalid strobe keep bank high
        cyc("R9", 1'b1, 8'h43, 1'b0, 11'h0, 1'b0);
        cyc("R9", 1'b1, 8'h62, 1'b0, 11'h0, 1'b0);
        cyc("R9", 1'b0, 8'h63, 1'b0, 11'h0, 1'b0);
        cyc("R9", 1'b0, 8'h33, 1'b1, 11'h055, 1'b0);

        // R10: jump beats step, idle holds
        cyc("R10", 1'b0, 8'h00, 1'b1, 11'h200, 1'b1);
        cyc("R10", 1'b0, 8'h00, 1'b0, 11'h3AA, 1'b0);

        // R7: enable flag set and sticky
        cyc("R7", 1'b1, 8'h33, 1'b0, 11'h0, 1'b0);
        cyc("R7", 1'b1, 8'h63, 1'b1, 11'h001, 1'b0);
        cyc("R7", 1'b1, 8'h00, 1'b0, 11'h0, 1'b1);

        // R7 / R1: only reset clears the flag
        do_reset();
        cyc("R7 cleared", 1'b0, 8'h00, 1'b0, 11'h0, 1'b0);
        cyc("R1 bank lo", 1'b0, 8'h00, 1'b1, 11'h456, 1'b0);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned pick;
            logic [7:0]  op;
            logic        v, j, s;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    op = 8'h63;
                2, 3:    op = 8'h73;
                4:       op = 8'h33;
                default: op = 8'($urandom);
            endcase
            v = ($urandom_range(0, 3) != 0);
            j = ($urandom_range(0, 3) == 0);
            s = ($urandom_range(0, 1) == 1);
            cyc(j ? "R5" : (s ? "R6" : "R10"), v, op, j, 11'($urandom), s);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule